// File: doc/BRIEF.md
# Paged Flash Erase Sequencer

This block turns one erase request, given as a byte start address and a byte length, into the series of erase commands that a paged serial flash needs. It sends the commands over a byte-level SPI transaction port. At each step it checks whether the current page sits on an eight-page boundary and whether at least eight pages are still left. If both hold, it sends one block erase that covers eight pages. Otherwise it erases a single page. After every erase command it polls the device status until the ready flag appears. Between busy polls it waits for a programmable number of idle cycles.

The page size in bytes and the left shift that turns a page index into a device address are configuration inputs. This lets the same block serve parts with page sizes that are not a power of two, such as 264, 528 or 1056 bytes. The block first divides the start address and the length by the page size, one bit per cycle. It rejects the request if either division leaves a remainder. When the last page is erased it pulses a completion flag.

Top module: `flash_erase_seq`

## Requirements
- R1: If the start address or the length is not a whole multiple of `cfg_page_size`, or `cfg_page_size` is zero, `err` pulses for one cycle, `done` stays low and no chip-select frame is opened.
- R2: An aligned request with zero length ends with a `done` pulse and opens no chip-select frame.
- R3: A block erase (opcode 0x50) is sent when the low three bits of the current page index are zero and at least eight pages remain.
- R4: In every other case a page erase (opcode 0x81) is sent.
- R5: Every erase frame is four bytes long. Byte 0 is the opcode, byte 1 is device address bits 23:16, byte 2 is bits 15:8, and byte 3 is 0x00. The device address is the page index shifted left by `cfg_page_shift`.
- R6: After each erase frame, status frames of two bytes (0xD7, then a dummy 0x00) are repeated until the byte received in the second slot has bit 7 set. Only then does the next erase or completion follow.
- R7: Before a status frame that follows a busy status frame, chip select stays low for at least `cfg_poll_gap` cycles.
- R8: A block erase advances the page index and reduces the remaining count by eight pages. A page erase changes each by one. The request completes when the count reaches zero.
- R9: Each command or status frame has its own chip-select assertion. Chip select goes low between frames, and `spi_go` is raised only while chip select is high.
- R10: `busy` is high from the cycle after a request is accepted until completion. `done` is a single-cycle pulse and never coincides with `err`. A request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Erase request strobe, taken only when idle |
| req_addr | input | ADDR_W | Byte start address |
| req_len | input | ADDR_W | Byte length |
| cfg_page_size | input | PS_W | Bytes per page |
| cfg_page_shift | input | SH_W | Left shift from page index to device address |
| cfg_poll_gap | input | GAP_W | Idle cycles inserted after a busy status read |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle alignment error pulse |
| spi_cs | output | 1 | Frame active (chip select, active high here) |
| spi_go | output | 1 | Start one byte transfer |
| spi_tx | output | 8 | Byte to transmit, stable while the frame is open |
| spi_done | input | 1 | Byte transfer finished |
| spi_rx | input | 8 | Byte received, valid with spi_done |

## Verification
The assertions in the RTL check properties on every cycle. They confirm that a block erase opcode is never sent from a misaligned page or with fewer than eight pages left, that byte strobes stay inside a frame, that a new frame starts only after chip select has dropped, that the remaining count is never zero during an erase, and that `done` is a lone pulse that never coincides with `err`. Some behaviour can only be shown by the bench's sweep against an arithmetic model. This covers the exact sequence of opcodes and address bytes across start pages and lengths, the number of status polls under different busy times, the idle gap length, the high address byte at a 528-byte page size, rejection of misaligned requests, and a request ignored while busy.

// File: rtl/ferase_pkg.sv
package ferase_pkg;
   localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
   localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
   localparam logic [7:0] OP_STATUS      = 8'hD7;
   localparam int         BLK_LOG2       = 3;
   localparam int         BLK_PAGES      = 1 << BLK_LOG2;
   localparam int         READY_BIT      = 7;
   localparam int         FRAME_MAX      = 4;

   typedef enum logic [2:0] {
      S_IDLE, S_DIVA, S_DIVL, S_ECMD, S_EWAIT, S_PCMD, S_PWAIT, S_GAP
   } seq_state_t;

   typedef enum logic [1:0] {
      F_IDLE, F_ISSUE, F_WAIT
   } frame_state_t;
endpackage

// File: rtl/ferase_div.sv
module ferase_div #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         fin,
   output logic [W-1:0] quot,
   output logic [W-1:0] rem
);
   localparam int CW = $clog2(W + 1);

   logic [CW-1:0] cnt;
   logic          run;
   logic [W-1:0]  dsr;
   logic [W:0]    trial;
   logic          fits;

   if (W < 2) begin : g_bad_w
      $error("ferase_div: W must be at least 2");
   end

   always_comb begin
      trial = {rem, quot[W-1]};
      fits  = (trial >= {1'b0, dsr});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         run  <= 1'b0;
         fin  <= 1'b0;
         quot <= '0;
         rem  <= '0;
         dsr  <= '0;
      end else begin
         fin <= 1'b0;
         if (start) begin
            rem  <= '0;
            quot <= dividend;
            dsr  <= divisor;
            cnt  <= CW'(W);
            run  <= 1'b1;
         end else if (run) begin
            rem  <= fits ? W'(trial - {1'b0, dsr}) : trial[W-1:0];
            quot <= {quot[W-2:0], fits};
            cnt  <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               run <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end

   // the partial remainder always stays below a nonzero divisor
   a_r1_rem_below_div: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && dsr != '0) |-> (rem < dsr));
endmodule

// File: rtl/ferase_gap.sv
module ferase_gap #(
   parameter int GAP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [GAP_W-1:0] len,
   output logic             expired
);
   logic [GAP_W-1:0] cnt;

   assign expired = run && (cnt >= len);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || expired)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   a_r7_gap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= len));
endmodule

// File: rtl/ferase_frame.sv
module ferase_frame
   import ferase_pkg::*;
(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [2:0]                nbytes,
   input  logic [FRAME_MAX-1:0][7:0] cmd,
   output logic                      fdone,
   output logic [7:0]                last_rx,
   output logic                      spi_cs,
   output logic                      spi_go,
   output logic [7:0]                spi_tx,
   input  logic                      spi_done,
   input  logic [7:0]                spi_rx
);
   frame_state_t              st;
   logic [FRAME_MAX-1:0][7:0] cmd_r;
   logic [2:0]                n_r;
   logic [1:0]                idx;
   logic                      last_byte;

   assign spi_go    = (st == F_ISSUE);
   assign spi_tx    = cmd_r[idx];
   assign last_byte = ({1'b0, idx} == (n_r - 3'd1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= F_IDLE;
         cmd_r   <= '0;
         n_r     <= 3'd1;
         idx     <= '0;
         spi_cs  <= 1'b0;
         fdone   <= 1'b0;
         last_rx <= '0;
      end else begin
         fdone <= 1'b0;
         case (st)
            F_IDLE: if (start) begin
               cmd_r  <= cmd;
               n_r    <= nbytes;
               idx    <= '0;
               spi_cs <= 1'b1;
               st     <= F_ISSUE;
            end
            F_ISSUE: st <= F_WAIT;
            F_WAIT: if (spi_done) begin
               last_rx <= spi_rx;
               if (last_byte) begin
                  spi_cs <= 1'b0;
                  fdone  <= 1'b1;
                  st     <= F_IDLE;
               end else begin
                  idx <= idx + 1'b1;
                  st  <= F_ISSUE;
               end
            end
            default: st <= F_IDLE;
         endcase
      end
   end

   a_r9_go_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
      spi_go |-> spi_cs);
   a_r9_start_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !spi_cs);
   a_r9_cs_low_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      fdone |-> !spi_cs);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
   import ferase_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int PS_W     = 12,
   parameter int SH_W     = 4,
   parameter int GAP_W    = 8,
   parameter bit BLOCK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ADDR_W-1:0] req_len,
   input  logic [PS_W-1:0]   cfg_page_size,
   input  logic [SH_W-1:0]   cfg_page_shift,
   input  logic [GAP_W-1:0]  cfg_poll_gap,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              spi_cs,
   output logic              spi_go,
   output logic [7:0]        spi_tx,
   input  logic              spi_done,
   input  logic [7:0]        spi_rx
);
   localparam int DEV_W = 32;

   if (ADDR_W < BLK_LOG2 + 1 || ADDR_W > DEV_W) begin : g_bad_addr
      $error("flash_erase_seq: ADDR_W out of range");
   end
   if (PS_W > ADDR_W || PS_W < 1) begin : g_bad_ps
      $error("flash_erase_seq: PS_W must lie in 1..ADDR_W");
   end
   if (SH_W > 5 || SH_W < 1) begin : g_bad_sh
      $error("flash_erase_seq: SH_W must lie in 1..5");
   end

   seq_state_t                state;
   logic [ADDR_W-1:0]         len_r, pidx, npages, rem_a;
   logic                      blk;
   logic                      use_blk;
   logic [DEV_W-1:0]          dev;
   logic                      div_start, div_fin;
   logic [ADDR_W-1:0]         div_a, div_q, div_r;
   logic                      fr_start, fr_done;
   logic [2:0]                fr_n;
   logic [FRAME_MAX-1:0][7:0] fr_cmd;
   logic [7:0]                fr_rx;
   logic                      gap_exp;
   logic [ADDR_W-1:0]         step;

   if (BLOCK_EN) begin : g_block
      assign use_blk = (pidx[BLK_LOG2-1:0] == '0) && (npages >= ADDR_W'(BLK_PAGES));
   end else begin : g_page_only
      assign use_blk = 1'b0;
   end

   assign busy      = (state != S_IDLE);
   assign dev       = DEV_W'(pidx) << cfg_page_shift;
   assign step      = blk ? ADDR_W'(BLK_PAGES) : ADDR_W'(1);
   assign div_a     = (state == S_IDLE) ? req_addr : len_r;
   assign div_start = ((state == S_IDLE) && req_valid) || ((state == S_DIVA) && div_fin);
   assign fr_start  = (state == S_ECMD) || (state == S_PCMD);
   assign fr_n      = (state == S_ECMD) ? 3'd4 : 3'd2;

   always_comb begin
      if (state == S_ECMD)
         fr_cmd = {8'h00, dev[15:8], dev[23:16], use_blk ? OP_BLOCK_ERASE : OP_PAGE_ERASE};
      else
         fr_cmd = {8'h00, 8'h00, 8'h00, OP_STATUS};
   end

   ferase_div #(.W(ADDR_W)) u_div (
      .clk(clk), .rst_n(rst_n), .start(div_start), .dividend(div_a),
      .divisor(ADDR_W'(cfg_page_size)), .fin(div_fin), .quot(div_q), .rem(div_r)
   );

   ferase_frame u_frame (
      .clk(clk), .rst_n(rst_n), .start(fr_start), .nbytes(fr_n), .cmd(fr_cmd),
      .fdone(fr_done), .last_rx(fr_rx), .spi_cs(spi_cs), .spi_go(spi_go),
      .spi_tx(spi_tx), .spi_done(spi_done), .spi_rx(spi_rx)
   );

   ferase_gap #(.GAP_W(GAP_W)) u_gap (
      .clk(clk), .rst_n(rst_n), .run(state == S_GAP), .len(cfg_poll_gap),
      .expired(gap_exp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         len_r  <= '0;
         pidx   <= '0;
         npages <= '0;
         rem_a  <= '0;
         blk    <= 1'b0;
         done   <= 1'b0;
         err    <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         case (state)
            S_IDLE: if (req_valid) begin
               len_r <= req_len;
               state <= S_DIVA;
            end
            S_DIVA: if (div_fin) begin
               pidx  <= div_q;
               rem_a <= div_r;
               state <= S_DIVL;
            end
            S_DIVL: if (div_fin) begin
               if (rem_a != '0 || div_r != '0 || cfg_page_size == '0) begin
                  err   <= 1'b1;
                  state <= S_IDLE;
               end else if (div_q == '0) begin
                  done  <= 1'b1;
                  state <= S_IDLE;
               end else begin
                  npages <= div_q;
                  state  <= S_ECMD;
               end
            end
            S_ECMD: begin
               blk   <= use_blk;
               state <= S_EWAIT;
            end
            S_EWAIT: if (fr_done) state <= S_PCMD;
            S_PCMD:  state <= S_PWAIT;
            S_PWAIT: if (fr_done) begin
               if (fr_rx[READY_BIT]) begin
                  pidx   <= pidx + step;
                  npages <= npages - step;
                  if (npages == step) begin
                     done  <= 1'b1;
                     state <= S_IDLE;
                  end else begin
                     state <= S_ECMD;
                  end
               end else begin
                  state <= S_GAP;
               end
            end
            S_GAP: if (gap_exp) state <= S_PCMD;
            default: state <= S_IDLE;
         endcase
      end
   end

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r10_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, err}));
   a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid) |=> busy);
   a_r3_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_go && spi_tx == OP_BLOCK_ERASE && $past(state) == S_ECMD)
         |-> (pidx[BLK_LOG2-1:0] == '0 && npages >= ADDR_W'(BLK_PAGES)));
   a_r8_pages_left: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_EWAIT || state == S_PWAIT || state == S_GAP) |-> (npages >= step));
   a_r1_err_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !spi_cs);
endmodule

// File: tb/sim_flash_erase_seq.sv
module sim_flash_erase_seq;
   localparam int AW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [AW-1:0] req_len = '0;
   logic [11:0]   cfg_page_size = 12'd264;
   logic [3:0]    cfg_page_shift = 4'd9;
   logic [7:0]    cfg_poll_gap = 8'd3;
   logic          busy, done, err, spi_cs, spi_go;
   logic [7:0]    spi_tx;
   logic          spi_done = 1'b0;
   logic [7:0]    spi_rx = '0;

   int nchk = 0;
   int nfail = 0;

   always #10 clk = ~clk;

   flash_erase_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_len(req_len), .cfg_page_size(cfg_page_size), .cfg_page_shift(cfg_page_shift),
      .cfg_poll_gap(cfg_poll_gap), .busy(busy), .done(done), .err(err),
      .spi_cs(spi_cs), .spi_go(spi_go), .spi_tx(spi_tx), .spi_done(spi_done),
      .spi_rx(spi_rx)
   );

   // device model: byte takes three cycles, frames logged at chip-select fall
   int        busy_cfg = 0;
   int        polls_left = 0;
   int        cur_n = 0;
   logic [7:0] cur [0:3];
   int        nfr = 0;
   logic [7:0] lg [0:1023][0:3];
   int        lg_n [0:1023];
   int        lg_gap [0:1023];
   logic      pend = 1'b0;
   int        dly = 0;
   logic      prev_cs = 1'b0;
   int        lowc = 0;
   int        gap_at = 0;

   always @(posedge clk) begin
      spi_done <= 1'b0;
      prev_cs  <= spi_cs;
      if (spi_go) begin
         if (cur_n < 4) cur[cur_n] <= spi_tx;
         cur_n <= cur_n + 1;
         pend  <= 1'b1;
         dly   <= 2;
      end else if (pend) begin
         if (dly == 0) begin
            pend     <= 1'b0;
            spi_done <= 1'b1;
            if (cur_n == 2 && cur[0] == 8'hD7) begin
               if (polls_left == 0) spi_rx <= 8'h80;
               else begin
                  spi_rx     <= 8'h00;
                  polls_left <= polls_left - 1;
               end
            end else spi_rx <= 8'hFF;
         end else dly <= dly - 1;
      end
      if (spi_cs && !prev_cs) begin
         gap_at <= lowc;
         lowc   <= 0;
      end else if (!spi_cs) lowc <= lowc + 1;
      if (prev_cs && !spi_cs) begin
         for (int i = 0; i < 4; i++) lg[nfr % 1024][i] <= cur[i];
         lg_n[nfr % 1024]   <= cur_n;
         lg_gap[nfr % 1024] <= gap_at;
         nfr   <= nfr + 1;
         cur_n <= 0;
         if (cur[0] == 8'h50 || cur[0] == 8'h81) polls_left <= busy_cfg;
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 190000) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog R10 actual=%0d expected<190000", cyc);
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // returns 1 for done, 2 for err, 0 for timeout
   task automatic run_op(input int addr, input int len, input bit poke, output int res);
      int t;
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = AW'(addr);
      req_len   = AW'(len);
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R10 busy after accept", longint'(busy), 1);
      res = 0;
      t = 0;
      while (t < 30000) begin
         if (poke && t == 60) begin
            req_valid = 1'b1;
            req_addr  = '0;
            req_len   = AW'(528);
         end else req_valid = 1'b0;
         if (done || err) begin
            chk(!(done && err), "R10 done/err exclusive", {done, err}, 2);
            res = done ? 1 : 2;
            break;
         end
         @(negedge clk);
         t++;
      end
      req_valid = 1'b0;
      if (res == 1) begin
         @(negedge clk);
         chk(done == 1'b0, "R10 done single pulse", longint'(done), 0);
      end
   endtask

   task automatic check_seq(input int base, input int pstart, input int npg, input int k,
                            input int shift, input int gap);
      int fi, p, n;
      bit b;
      longint dv;
      fi = base;
      p  = pstart;
      n  = npg;
      while (n > 0) begin
         b  = (p % 8 == 0) && (n >= 8);
         dv = longint'(p) << shift;
         chk(lg_n[fi % 1024] == 4, "R5 erase frame length", lg_n[fi % 1024], 4);
         chk(lg[fi % 1024][0] == (b ? 8'h50 : 8'h81), b ? "R3 block opcode" : "R4 page opcode",
             lg[fi % 1024][0], b ? 8'h50 : 8'h81);
         chk({lg[fi % 1024][1], lg[fi % 1024][2], lg[fi % 1024][3]} == {8'(dv >> 16), 8'(dv >> 8), 8'h00},
             "R5 address bytes", {lg[fi % 1024][1], lg[fi % 1024][2], lg[fi % 1024][3]},
             {8'(dv >> 16), 8'(dv >> 8), 8'h00});
         fi++;
         for (int j = 0; j <= k; j++) begin
            chk(lg_n[fi % 1024] == 2 && lg[fi % 1024][0] == 8'hD7 && lg[fi % 1024][1] == 8'h00,
                "R6 status frame", {lg_n[fi % 1024][7:0], lg[fi % 1024][0], lg[fi % 1024][1]},
                {8'd2, 8'hD7, 8'h00});
            if (j > 0)
               chk(lg_gap[fi % 1024] >= gap, "R7 poll gap", lg_gap[fi % 1024], gap);
            chk(lg_gap[fi % 1024] >= 1, "R9 chip select drop", lg_gap[fi % 1024], 1);
            fi++;
         end
         p += b ? 8 : 1;
         n -= b ? 8 : 1;
      end
      chk(nfr - base == fi - base, "R8 frame count", nfr - base, fi - base);
   endtask

   initial begin
      int res, base;
      int lens [0:6] = '{0, 1, 7, 8, 9, 16, 17};
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && err == 0 && spi_cs == 0 && spi_go == 0,
          "R10 reset state", {busy, done, err, spi_cs, spi_go}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int s = 0; s < 10; s++) begin
         for (int li = 0; li < 7; li++) begin
            busy_cfg     = (s + li) % 3;
            cfg_poll_gap = 8'((s * 7 + li) % 5);
            base = nfr;
            run_op(s * 264, lens[li] * 264, (s == 3 && li == 5), res);
            chk(res == 1, lens[li] == 0 ? "R2 zero length done" : "R8 completes", res, 1);
            check_seq(base, s, lens[li], busy_cfg, 9, cfg_poll_gap);
         end
      end

      // larger page with high address byte
      cfg_page_size  = 12'd528;
      cfg_page_shift = 4'd10;
      busy_cfg       = 1;
      cfg_poll_gap   = 8'd4;
      base = nfr;
      run_op(1000 * 528, 10 * 528, 1'b0, res);
      chk(res == 1, "R8 completes 528", res, 1);
      check_seq(base, 1000, 10, 1, 10, 4);

      // alignment rejection
      base = nfr;
      run_op(4, 528, 1'b0, res);
      chk(res == 2, "R1 misaligned address", res, 2);
      run_op(528, 100, 1'b0, res);
      chk(res == 2, "R1 misaligned length", res, 2);
      cfg_page_size = 12'd0;
      run_op(0, 0, 1'b0, res);
      chk(res == 2, "R1 zero page size", res, 2);
      repeat (4) @(negedge clk);
      chk(nfr == base, "R1 no frames on error", nfr - base, 0);

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule